// File: doc/BRIEF.md
# Read Request Splitter with Tag Pool

This block is the requester front end of a DMA read engine. It accepts one transfer descriptor at a time, made of a starting byte address and a byte count, and breaks it into a stream of memory read requests. Each request carries an address, a length in dwords and a tag. The largest request it may issue is the smaller of two programmed limits: the read request size code and the payload size code. It also never lets a request run past a 4 KB address boundary.

Every request takes a tag from a small pool, and a tag stays busy until the completion logic reports the final completion for it. When every tag is busy, the block holds back the next request, so the pool size bounds the number of reads in flight. Once the last piece of a descriptor has been handed off and every tag it used has come back, the block raises a one-cycle done pulse and is ready for the next descriptor.

Top module: `rd_req_splitter`

## Requirements
- R1: Both 3-bit size codes decode as code 0 to 5 giving 128 shifted left by the code (128, 256, 512, 1024, 2048, 4096 bytes), and codes 6 and 7 giving 4096 bytes.
- R2: No request is larger than the smaller of the decoded `mrrs_code` and decoded `mps_code`, and no request has zero length.
- R3: Descriptor address and length are dword multiples. The requests of a descriptor are issued in address order, start at `desc_addr`, are contiguous and together cover exactly `desc_len` bytes. Each request is min(effective size, bytes remaining, bytes to the next 4 KB boundary) long, with `req_dw_len` equal to that byte count divided by 4.
- R4: No request crosses a 4 KB address boundary (address bits 11:0 restart).
- R5: A tag is never handed out again while an earlier request with that tag still awaits its final completion.
- R6: At most NTAG requests are outstanding. When all tags are busy, `req_valid` stays low.
- R7: A tag is released only by `cpl_valid` with `cpl_last` high. A completion with `cpl_last` low changes nothing.
- R8: A new request takes the lowest-numbered free tag. The first request after an idle period uses tag 0, and a single freed tag is the one reused next.
- R9: While `req_valid` is high and `req_ready` low, `req_valid` stays high and address, length and tag do not change.
- R10: `desc_ready` is high only when idle. A descriptor is taken when `desc_valid` and `desc_ready` are both high. `done` pulses for exactly one cycle after the last request was accepted and all of its tags were released, and `desc_ready` is high in that cycle. A zero-length descriptor issues no request and still produces `done`.
- R11: During reset `desc_ready` is 1, `req_valid` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrrs_code | input | 3 | Read request size code |
| mps_code | input | 3 | Payload size code that clamps the request size |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle and able to take a descriptor |
| desc_addr | input | AW | Start byte address, dword aligned |
| desc_len | input | LW | Transfer length in bytes, dword multiple |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Downstream takes the request |
| req_addr | output | AW | Request byte address |
| req_dw_len | output | 11 | Request length in dwords (1 to 1024) |
| req_tag | output | TW | Request tag |
| cpl_valid | input | 1 | Completion report valid |
| cpl_tag | input | TW | Tag of the reported completion |
| cpl_last | input | 1 | Report is the final completion for the tag |
| done | output | 1 | One-cycle pulse when a descriptor is finished |

## Verification
The bench sweeps every size code against several payload codes, with start addresses on a 4 KB boundary, just short of one and a dword before one, and lengths that do and do not fill a whole request. A wrong decode or clamp shows up as a request of the wrong length, and a missing boundary cut shows up as a request that runs into the next 4 KB page. A separate pass withholds completions until the pool is full, then sends only non-final completions and finally frees one middle tag. A design that frees tags early, ignores the pool limit or picks tags in the wrong order would issue a request during that hold or use a tag other than the freed one. Zero-length and single-dword descriptors check that done still arrives, and that it arrives only once the last tag is back.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  localparam int unsigned SZ_W = 13;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } rrs_state_e;

  // 3-bit size code to bytes; codes above 5 saturate at 4 KB
  function automatic logic [SZ_W-1:0] code_to_bytes(input logic [2:0] code);
    logic [SZ_W-1:0] b;
    if (code > 3'd5) b = 13'd4096;
    else             b = 13'd128 << code;
    return b;
  endfunction

endpackage

// File: rtl/rrs_size_dec.sv
module rrs_size_dec
  import rrs_pkg::*;
(
  input  logic [2:0]      rd_code,
  input  logic [2:0]      pl_code,
  output logic [SZ_W-1:0] eff_bytes
);
  logic [SZ_W-1:0] rd_bytes;
  logic [SZ_W-1:0] pl_bytes;

  always_comb begin
    rd_bytes  = code_to_bytes(rd_code);
    pl_bytes  = code_to_bytes(pl_code);
    eff_bytes = (rd_bytes < pl_bytes) ? rd_bytes : pl_bytes;
  end
endmodule

// File: rtl/rrs_chunk.sv
module rrs_chunk
  import rrs_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic [11:0]     page_off,
  input  logic [LW-1:0]   remain,
  input  logic [SZ_W-1:0] limit,
  output logic [SZ_W-1:0] chunk
);
  logic [SZ_W-1:0] to_bound;
  logic [SZ_W-1:0] rem_cap;
  logic [SZ_W-1:0] lim_rem;

  always_comb begin
    to_bound = 13'd4096 - {1'b0, page_off};
    rem_cap  = (remain > LW'(4095)) ? 13'd4096 : remain[SZ_W-1:0];
    lim_rem  = (limit < rem_cap) ? limit : rem_cap;
    chunk    = (lim_rem < to_bound) ? lim_rem : to_bound;
  end
endmodule

// File: rtl/rrs_tag_pool.sv
module rrs_tag_pool #(
  parameter int NTAG = 4,
  localparam int TW = (NTAG > 1) ? $clog2(NTAG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  output logic [TW-1:0] alloc_tag,
  output logic          any_free,
  input  logic          rel_en,
  input  logic [TW-1:0] rel_tag,
  output logic          idle
);
  logic [NTAG-1:0] busy_q;
  logic [NTAG-1:0] busy_d;
  logic            busy_en;

  // lowest free index wins
  always_comb begin
    alloc_tag = '0;
    any_free  = 1'b0;
    for (int i = NTAG - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        alloc_tag = TW'(i);
        any_free  = 1'b1;
      end
    end
    idle = (busy_q == '0);
  end

  always_comb begin
    busy_en = alloc_en | rel_en;
    busy_d  = busy_q;
    if (rel_en)   busy_d[rel_tag]   = 1'b0;
    if (alloc_en) busy_d[alloc_tag] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= '0;
    else if (busy_en) busy_q <= busy_d;
  end
endmodule

// File: rtl/rd_req_splitter.sv
module rd_req_splitter
  import rrs_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LW   = 16,
  parameter int NTAG = 4,
  localparam int TW  = (NTAG > 1) ? $clog2(NTAG) : 1,
  localparam int DLW = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     mrrs_code,
  input  logic [2:0]     mps_code,
  input  logic           desc_valid,
  output logic           desc_ready,
  input  logic [AW-1:0]  desc_addr,
  input  logic [LW-1:0]  desc_len,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [AW-1:0]  req_addr,
  output logic [DLW-1:0] req_dw_len,
  output logic [TW-1:0]  req_tag,
  input  logic           cpl_valid,
  input  logic [TW-1:0]  cpl_tag,
  input  logic           cpl_last,
  output logic           done
);
  rrs_state_e      st_q, st_d;
  logic [AW-1:0]   cur_q, cur_d;
  logic [LW-1:0]   rem_q, rem_d;
  logic            ov_q, ov_d;
  logic [AW-1:0]   oaddr_q;
  logic [DLW-1:0]  olen_q;
  logic [TW-1:0]   otag_q;
  logic            done_q, done_d;

  logic [SZ_W-1:0] eff_bytes;
  logic [SZ_W-1:0] chunk;
  logic [TW-1:0]   free_tag;
  logic            any_free;
  logic            pool_idle;
  logic            fire, slot_open, load, accept, rel_en;

  rrs_size_dec u_dec (
    .rd_code  (mrrs_code),
    .pl_code  (mps_code),
    .eff_bytes(eff_bytes)
  );

  rrs_chunk #(.LW(LW)) u_chunk (
    .page_off(cur_q[11:0]),
    .remain  (rem_q),
    .limit   (eff_bytes),
    .chunk   (chunk)
  );

  rrs_tag_pool #(.NTAG(NTAG)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_en (load),
    .alloc_tag(free_tag),
    .any_free (any_free),
    .rel_en   (rel_en),
    .rel_tag  (cpl_tag),
    .idle     (pool_idle)
  );

  always_comb begin
    desc_ready = (st_q == ST_IDLE);
    accept     = desc_valid & desc_ready;
    fire       = ov_q & req_ready;
    slot_open  = ~ov_q | req_ready;
    load       = (st_q == ST_ISSUE) && (rem_q != '0) && any_free && slot_open;
    rel_en     = cpl_valid & cpl_last;
  end

  // next state
  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    rem_d  = rem_q;
    done_d = 1'b0;
    ov_d   = load ? 1'b1 : (fire ? 1'b0 : ov_q);
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          cur_d = desc_addr;
          rem_d = desc_len;
          st_d  = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (load) begin
          cur_d = cur_q + AW'(chunk);
          rem_d = rem_q - LW'(chunk);
        end
        if ((rem_q == '0) && (!ov_q || fire)) st_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (pool_idle) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      rem_q  <= '0;
      ov_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      rem_q  <= rem_d;
      ov_q   <= ov_d;
      done_q <= done_d;
    end
  end

  // output payload, enabled by load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oaddr_q <= '0;
      olen_q  <= '0;
      otag_q  <= '0;
    end else if (load) begin
      oaddr_q <= cur_q;
      olen_q  <= chunk[SZ_W-1:2];
      otag_q  <= free_tag;
    end
  end

  assign req_valid  = ov_q;
  assign req_addr   = oaddr_q;
  assign req_dw_len = olen_q;
  assign req_tag    = otag_q;
  assign done       = done_q;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
  parameter int AW   = 32,
  parameter int NTAG = 4,
  localparam int TW  = (NTAG > 1) ? $clog2(NTAG) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mrrs_code,
  input logic [2:0]    mps_code,
  input logic          desc_ready,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [10:0]   req_dw_len,
  input logic [TW-1:0] req_tag,
  input logic          cpl_valid,
  input logic [TW-1:0] cpl_tag,
  input logic          cpl_last,
  input logic          done
);
  logic [NTAG-1:0] live_q, live_d;
  logic [AW-1:0]   last_byte;
  int              lim;

  function automatic int cap_of(input logic [2:0] c);
    case (c)
      3'd0:    return 128;
      3'd1:    return 256;
      3'd2:    return 512;
      3'd3:    return 1024;
      3'd4:    return 2048;
      default: return 4096;
    endcase
  endfunction

  // shadow of tags accepted downstream and not yet finally completed
  always_comb begin
    live_d = live_q;
    if (cpl_valid && cpl_last)  live_d[cpl_tag] = 1'b0;
    if (req_valid && req_ready) live_d[req_tag] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= '0;
    else        live_q <= live_d;
  end

  always_comb begin
    lim       = (cap_of(mrrs_code) < cap_of(mps_code)) ? cap_of(mrrs_code) : cap_of(mps_code);
    last_byte = req_addr + AW'({req_dw_len, 2'b00}) - AW'(1);
  end

  assert_len_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((int'(req_dw_len) * 4 <= lim) && (req_dw_len != '0)));

  assert_no_page_cross_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (last_byte[AW-1:12] == req_addr[AW-1:12]));

  assert_unique_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> !live_q[req_tag]);

  assert_pool_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&live_q) |-> !req_valid);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_dw_len) && $stable(req_tag)));

  assert_done_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((live_q == '0) && desc_ready));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind rd_req_splitter rrs_checker #(.AW(AW), .NTAG(NTAG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mrrs_code (mrrs_code),
  .mps_code  (mps_code),
  .desc_ready(desc_ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_dw_len(req_dw_len),
  .req_tag   (req_tag),
  .cpl_valid (cpl_valid),
  .cpl_tag   (cpl_tag),
  .cpl_last  (cpl_last),
  .done      (done)
);

// File: tb/sim_rd_req_splitter.sv
module sim_rd_req_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int NTAG = 4;
  localparam int TW = 2;

  logic          clk, rst_n;
  logic [2:0]    mrrs_code, mps_code;
  logic          desc_valid, desc_ready;
  logic [AW-1:0] desc_addr;
  logic [LW-1:0] desc_len;
  logic          req_valid, req_ready;
  logic [AW-1:0] req_addr;
  logic [10:0]   req_dw_len;
  logic [TW-1:0] req_tag;
  logic          cpl_valid, cpl_last;
  logic [TW-1:0] cpl_tag;
  logic          done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  rd_req_splitter #(.AW(AW), .LW(LW), .NTAG(NTAG)) u0 (
    .clk(clk), .rst_n(rst_n), .mrrs_code(mrrs_code), .mps_code(mps_code),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
    .desc_len(desc_len), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_dw_len(req_dw_len), .req_tag(req_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_last(cpl_last), .done(done)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dec(input int code);
    return (code <= 5) ? (128 << code) : 4096;
  endfunction

  task automatic run_desc(input int addr, input int len, input int mc, input int pc, input bit stall);
    int  cur = addr;
    int  rem = len;
    int  eff = (dec(mc) < dec(pc)) ? dec(mc) : dec(pc);
    int  outq[$];
    bit  stage = 0;
    bit  first = 1;
    bit  stall_done = !stall;
    int  want_tag = -1;
    int  guard = 0;
    bit  done_seen = 0;
    bit  rdy;
    @(negedge clk);
    mrrs_code = 3'(mc); mps_code = 3'(pc);
    desc_addr = AW'(addr); desc_len = LW'(len); desc_valid = 1'b1;
    check(desc_ready == 1'b1, "R10 desc_ready idle", int'(desc_ready), 1);
    @(negedge clk);
    desc_valid = 1'b0;
    while (!done_seen && guard < 20000) begin
      guard++;
      cpl_valid = 1'b0; cpl_last = 1'b0;
      if (done) begin
        check(rem == 0, "R10 done after all issued", rem, 0);
        check(outq.size() == 0, "R10 done after all released", outq.size(), 0);
        done_seen = 1;
      end else begin
        if (!stall_done && outq.size() == NTAG) begin
          req_ready = 1'b0;
          repeat (6) begin
            @(negedge clk);
            check(req_valid == 1'b0, "R6 stall with pool full", int'(req_valid), 0);
          end
          foreach (outq[k]) begin
            cpl_valid = 1'b1; cpl_last = 1'b0; cpl_tag = TW'(outq[k]);
            @(negedge clk);
          end
          cpl_valid = 1'b0;
          repeat (4) begin
            @(negedge clk);
            check(req_valid == 1'b0, "R7 non-final completion frees nothing", int'(req_valid), 0);
          end
          for (int k = 0; k < outq.size(); k++) begin
            if (outq[k] == 2) begin
              outq.delete(k);
              break;
            end
          end
          cpl_valid = 1'b1; cpl_last = 1'b1; cpl_tag = 2'd2;
          want_tag = 2;
          stall_done = 1;
        end else if (stall_done && outq.size() > 0 && (cyc % 3) == 0) begin
          cpl_valid = 1'b1; cpl_tag = TW'(outq[0]);
          if (!stage) begin
            cpl_last = 1'b0; stage = 1;
          end else begin
            cpl_last = 1'b1; stage = 0;
            void'(outq.pop_front());
          end
        end
        rdy = !stall_done ? 1'b1 : ((cyc % 5) != 3);
        if (req_valid && rdy) begin
          int room = 4096 - (cur % 4096);
          int exp_b = eff;
          bit dup = 0;
          if (rem < exp_b) exp_b = rem;
          if (room < exp_b) exp_b = room;
          check(rem > 0, "R3 no request beyond length", rem, 1);
          check(req_addr == AW'(cur), "R3 request address", int'(req_addr), cur);
          check(int'(req_dw_len) == exp_b / 4, "R3 request dword length", int'(req_dw_len), exp_b / 4);
          check(int'(req_dw_len) * 4 <= eff, "R2 clamp to smaller size", int'(req_dw_len) * 4, eff);
          check((int'(req_addr) % 4096) + int'(req_dw_len) * 4 <= 4096, "R4 page boundary",
                (int'(req_addr) % 4096) + int'(req_dw_len) * 4, 4096);
          foreach (outq[k]) if (outq[k] == int'(req_tag)) dup = 1;
          check(!dup, "R5 tag unique in flight", int'(req_tag), -1);
          if (first) check(req_tag == '0, "R8 first tag lowest", int'(req_tag), 0);
          if (want_tag >= 0) begin
            check(int'(req_tag) == want_tag, "R8 freed tag reused", int'(req_tag), want_tag);
            want_tag = -1;
          end
          check(outq.size() < NTAG, "R6 in-flight bound", outq.size(), NTAG - 1);
          first = 0;
          outq.push_back(int'(req_tag));
          cur += exp_b;
          rem -= exp_b;
        end
        req_ready = rdy;
      end
      @(negedge clk);
    end
    check(done_seen, "R10 done raised", int'(done_seen), 1);
    cpl_valid = 1'b0; req_ready = 1'b0;
    check(done == 1'b0, "R10 done one cycle", int'(done), 0);
  endtask

  initial begin
    int pcs[4] = '{0, 1, 5, 7};
    int addrs[3] = '{32'h0000, 32'h3F80, 32'h1FFC};
    int lens[3] = '{4, 600, 4100};
    rst_n = 1'b0; desc_valid = 1'b0; req_ready = 1'b0; cpl_valid = 1'b0;
    cpl_last = 1'b0; cpl_tag = '0; mrrs_code = '0; mps_code = '0;
    desc_addr = '0; desc_len = '0;
    repeat (3) @(negedge clk);
    check(desc_ready == 1'b1, "R11 reset desc_ready", int'(desc_ready), 1);
    check(req_valid == 1'b0, "R11 reset req_valid", int'(req_valid), 0);
    check(done == 1'b0, "R11 reset done", int'(done), 0);
    rst_n = 1'b1;
    // zero-length descriptor still completes
    run_desc(32'h100, 0, 0, 0, 0);
    // stall, non-final completions and single-tag reuse
    run_desc(32'h0, 4096, 0, 5, 1);
    // sweep of size codes (R1) against clamp, offsets and lengths
    for (int mc = 0; mc < 8; mc++)
      foreach (pcs[p])
        foreach (addrs[a])
          foreach (lens[l])
            run_desc(addrs[a], lens[l], mc, pcs[p], 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule